// File: doc/BRIEF.md
# Configuration Change Protection Unit

This block keeps software from changing critical I/O registers, or from running the protected program-memory store and load instructions, by accident. The CPU must first write a signature byte to one protection address on the data bus. There are two signatures. One opens a short I/O unlock window, during which a single write to a protected register goes through. The other opens an instruction unlock window, during which a single protected store or load instruction is allowed. Each window lasts a fixed number of instruction cycles. It also closes at once when the CPU does anything else that touches data.

The block watches the CPU's write port: address, write data and write strobe. It also takes an instruction-cycle tick and decoded pulses that mark the execution of a program-memory store, a program-memory load or a sleep instruction. It drives a gated write enable for the protected register file, an allow flag for the protected instructions, one flag per unlock mode, and a status byte that can be read back at the protection address. The protected registers and the instruction decoder are outside this block.

Top module: `ccp_guard`

## Requirements
- R1: After reset both unlock flags are low, `prot_we` and `insn_allow` are low, and the status byte reads 8'h00.
- R2: A write of `IO_SIG` (default 8'hD8) to `CCP_ADDR` raises `io_unlocked` from the next cycle onward.
- R3: A write of `INSN_SIG` (default 8'h9D) to `CCP_ADDR` raises `insn_unlocked` from the next cycle onward. At most one mode is open at a time, and the most recent signature decides which one.
- R4: A write of any other value to `CCP_ADDR` is ignored. Both flags and the remaining window keep their state.
- R5: An open window closes after `WINDOW` (default 4) rising edges with `insn_tick` high, counted from the signature write. It stays open through the first `WINDOW-1` of those edges.
- R6: `prot_we` is high in the same cycle only when all of the following hold: `io_unlocked` is high, `bus_we` is high, `bus_addr` is in the range `PROT_BASE` to `PROT_BASE+PROT_NUM-1`, and bit `CE_BIT` (default 0) of `bus_wdata` is 1.
- R7: Any bus write to an address other than `CCP_ADDR` closes both modes from the next cycle. This includes a write that succeeds on a protected register.
- R8: A high `exec_store`, `exec_load` or `exec_sleep` closes both modes from the next cycle.
- R9: `insn_allow` is high in the same cycle exactly when `insn_unlocked` is high and `exec_store` or `exec_load` is high. The first allowed instruction uses up the unlock.
- R10: A signature write while a window is open restarts the count at `WINDOW`. If a tick arrives in the same cycle, the signature takes priority.
- R11: `bus_rdata` equals `{6'b0, io_unlocked, insn_unlocked}` when `bus_addr` equals `CCP_ADDR`, and 8'h00 otherwise. Bit 1 is the I/O mode and bit 0 is the instruction mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | CPU data-bus write strobe |
| bus_addr | input | ADDR_W | CPU data-bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Status byte when the protection address is selected |
| insn_tick | input | 1 | One pulse per instruction cycle |
| exec_store | input | 1 | Protected program-memory store is executing |
| exec_load | input | 1 | Protected program-memory load is executing |
| exec_sleep | input | 1 | Sleep instruction is executing |
| io_unlocked | output | 1 | I/O unlock window open |
| insn_unlocked | output | 1 | Instruction unlock window open |
| prot_we | output | 1 | Gated write enable for the protected registers |
| insn_allow | output | 1 | Protected instruction allowed this cycle |

## Verification
The hardest case to reach from the ports is a window that ends at the exact edge where something else happens: a signature rewrite that lands together with a tick, or a window kept open through three ticks and then closed by the fourth. The stimulus reaches these cases with deliberate sequences of signature, tick and idle cycles. A reference model in the bench tracks the remaining count, and every cycle is compared to it, so an off-by-one in the count or a wrong priority shows up as a wrong flag. Cancellation is exercised by every kind of event that can cause it, in both modes: a plain write, a successful protected write, a write without the change-enable bit, a store, a load and a sleep.

// File: rtl/ccp_pkg.sv
// Shared constants for the configuration change protection unit.
// Assumes exactly two unlock modes, indexed to match the status byte bits.
package ccp_pkg;
    localparam int N_MODES   = 2;
    localparam int MODE_INSN = 0;   // status bit 0
    localparam int MODE_IO   = 1;   // status bit 1
    typedef logic [N_MODES-1:0] mode_vec_t;
endpackage

// File: rtl/ccp_bus_decode.sv
// Decodes one CPU bus cycle into the events the unlock windows react to.
// Assumes a single-beat write: address, data and strobe are valid together.
module ccp_bus_decode #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CCP_ADDR  = 12'h034,
    parameter logic [ADDR_W-1:0] PROT_BASE = 12'h040,
    parameter int                PROT_NUM  = 4,
    parameter int                CE_BIT    = 0,
    parameter logic [7:0]        IO_SIG    = 8'hD8,
    parameter logic [7:0]        INSN_SIG  = 8'h9D
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              sig_io,
    output logic              sig_insn,
    output logic              other_wr,
    output logic              prot_sel
);
    localparam logic [ADDR_W-1:0] PROT_LAST = PROT_BASE + ADDR_W'(PROT_NUM - 1);

    logic ccp_hit;
    logic in_range;

    // Classify the current write by target address and signature value.
    always_comb begin
        ccp_hit  = (bus_addr == CCP_ADDR);
        in_range = (bus_addr >= PROT_BASE) && (bus_addr <= PROT_LAST);
        sig_io   = bus_we && ccp_hit && (bus_wdata == IO_SIG);
        sig_insn = bus_we && ccp_hit && (bus_wdata == INSN_SIG);
        other_wr = bus_we && !ccp_hit;
        prot_sel = bus_we && in_range && bus_wdata[CE_BIT];
    end
endmodule

// File: rtl/ccp_window.sv
// One unlock window: opened by a load pulse, closed by a kill pulse or
// after WINDOW instruction ticks. Load has priority over kill and tick.
module ccp_window #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic kill,
    input  logic tick,
    output logic active
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    logic [CNT_W-1:0] cnt;

    // Open, count down per tick, and close on expiry or cancellation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= CNT_W'(WINDOW);
        end else if (kill) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (tick && active) begin
            if (cnt == CNT_W'(1)) active <= 1'b0;
            cnt <= cnt - CNT_W'(1);
        end
    end

    AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active && (cnt == CNT_W'(WINDOW)));                     // R10
    AST_KILL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !load) |=> !active);                                     // R7
    AST_LAPSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active && cnt == CNT_W'(1) && !load) |=> !active);       // R5
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0) && (cnt <= CNT_W'(WINDOW)));               // R5
endmodule

// File: rtl/ccp_guard.sv
// Configuration change protection unit. Watches CPU writes for a signature
// at CCP_ADDR, keeps one unlock window per mode, gates protected register
// writes and protected instructions, and presents a status byte.
// Assumes exec_* pulses last one clock per executed instruction.
module ccp_guard
    import ccp_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CCP_ADDR  = 12'h034,
    parameter logic [ADDR_W-1:0] PROT_BASE = 12'h040,
    parameter int                PROT_NUM  = 4,
    parameter int                CE_BIT    = 0,
    parameter logic [7:0]        IO_SIG    = 8'hD8,
    parameter logic [7:0]        INSN_SIG  = 8'h9D,
    parameter int                WINDOW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              insn_tick,
    input  logic              exec_store,
    input  logic              exec_load,
    input  logic              exec_sleep,
    output logic              io_unlocked,
    output logic              insn_unlocked,
    output logic              prot_we,
    output logic              insn_allow
);
    logic      sig_io, sig_insn, other_wr, prot_sel;
    logic      clear_all;
    mode_vec_t load_v, kill_v, active_v;

    ccp_bus_decode #(
        .ADDR_W(ADDR_W), .CCP_ADDR(CCP_ADDR), .PROT_BASE(PROT_BASE),
        .PROT_NUM(PROT_NUM), .CE_BIT(CE_BIT), .IO_SIG(IO_SIG), .INSN_SIG(INSN_SIG)
    ) u_decode (
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .sig_io(sig_io), .sig_insn(sig_insn), .other_wr(other_wr), .prot_sel(prot_sel)
    );

    // Events that end every open window at once.
    always_comb begin
        clear_all        = other_wr || exec_store || exec_load || exec_sleep;
        load_v           = '0;
        load_v[MODE_IO]   = sig_io;
        load_v[MODE_INSN] = sig_insn;
    end

    // One window per mode; the other mode's signature also closes it.
    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        assign kill_v[m] = clear_all || (load_v[N_MODES-1-m]);
        ccp_window #(.WINDOW(WINDOW)) u_window (
            .clk(clk), .rst_n(rst_n), .load(load_v[m]), .kill(kill_v[m]),
            .tick(insn_tick), .active(active_v[m])
        );
    end

    // Output gating and status read-back.
    always_comb begin
        io_unlocked   = active_v[MODE_IO];
        insn_unlocked = active_v[MODE_INSN];
        prot_we       = prot_sel && active_v[MODE_IO];
        insn_allow    = active_v[MODE_INSN] && (exec_store || exec_load);
        bus_rdata     = (bus_addr == CCP_ADDR) ? {{(8-N_MODES){1'b0}}, active_v} : 8'h00;
    end

    AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_unlocked, insn_unlocked}));                           // R3
    AST_SIG_IO_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        sig_io |=> io_unlocked && !insn_unlocked);                          // R2
    AST_WRITE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != CCP_ADDR) |=> !io_unlocked && !insn_unlocked); // R7
    AST_EXEC_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        ((exec_store || exec_load || exec_sleep) && !sig_io && !sig_insn)
            |=> !io_unlocked && !insn_unlocked);                            // R8
    AST_ALLOW_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_allow && !sig_insn) |=> !insn_unlocked);                      // R9
    AST_PROT_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |-> bus_we && $past(1'b1) && io_unlocked);                  // R6
endmodule

// File: tb/ccp_guard_tb.sv
// Scoreboard bench: the driver applies one bus cycle per clock and pushes the
// values a reference model expects; the monitor pops and compares them.
module ccp_guard_tb;
    localparam logic [11:0] CCP = 12'h034;
    localparam logic [11:0] P0  = 12'h040;
    localparam logic [7:0]  SIO = 8'hD8;
    localparam logic [7:0]  SIN = 8'h9D;

    typedef struct {
        string      tag;
        logic       pwe;
        logic       allow;
        logic       io;
        logic       insn;
        logic [7:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        insn_tick = 1'b0, exec_store = 1'b0, exec_load = 1'b0, exec_sleep = 1'b0;
    logic        io_unlocked, insn_unlocked, prot_we, insn_allow;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    // model state
    logic   m_io = 1'b0, m_insn = 1'b0;
    int     m_cnt = 0;

    always #4 clk = ~clk;

    ccp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .insn_tick(insn_tick),
        .exec_store(exec_store), .exec_load(exec_load), .exec_sleep(exec_sleep),
        .io_unlocked(io_unlocked), .insn_unlocked(insn_unlocked),
        .prot_we(prot_we), .insn_allow(insn_allow)
    );

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(logic we, logic [11:0] a, logic [7:0] d,
                       logic tk, logic st, logic ld, logic sl, string tag);
        exp_t e;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        insn_tick = tk; exec_store = st; exec_load = ld; exec_sleep = sl;
        e.tag   = tag;
        e.io    = m_io;
        e.insn  = m_insn;
        e.pwe   = m_io && we && (a >= P0) && (a <= P0 + 12'd3) && d[0];
        e.allow = m_insn && (st || ld);
        e.rd    = (a == CCP) ? {6'b0, m_io, m_insn} : 8'h00;
        q.push_back(e);
        if (we && a == CCP && d == SIO) begin
            m_io = 1'b1; m_insn = 1'b0; m_cnt = 4;
        end else if (we && a == CCP && d == SIN) begin
            m_io = 1'b0; m_insn = 1'b1; m_cnt = 4;
        end else if ((we && a != CCP) || st || ld || sl) begin
            m_io = 1'b0; m_insn = 1'b0; m_cnt = 0;
        end else if (tk && (m_io || m_insn)) begin
            m_cnt--;
            if (m_cnt == 0) begin m_io = 1'b0; m_insn = 1'b0; end
        end
    endtask

    task automatic idle(string tag);  cyc(0, CCP, 8'h00, 0, 0, 0, 0, tag); endtask
    task automatic tick(string tag);  cyc(0, CCP, 8'h00, 1, 0, 0, 0, tag); endtask
    task automatic sig(logic [7:0] s, string tag); cyc(1, CCP, s, 0, 0, 0, 0, tag); endtask

    // Monitor: compare each cycle's outputs just before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "prot_we",       8'(prot_we),       8'(e.pwe));
                chk(e.tag, "insn_allow",    8'(insn_allow),    8'(e.allow));
                chk(e.tag, "io_unlocked",   8'(io_unlocked),   8'(e.io));
                chk(e.tag, "insn_unlocked", 8'(insn_unlocked), 8'(e.insn));
                chk(e.tag, "bus_rdata",     bus_rdata,         e.rd);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus sequences per requirement.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1"); idle("R1");
        // R2 I/O unlock and R11 status
        sig(SIO, "R2"); idle("R2"); idle("R11");
        cyc(0, 12'h100, 8'h00, 0, 0, 0, 0, "R11");
        // R6 successful protected write, then R7 consumed
        cyc(1, P0 + 12'd1, 8'h81, 0, 0, 0, 0, "R6"); idle("R7");
        // R6 locked write has no effect
        cyc(1, P0, 8'h01, 0, 0, 0, 0, "R6"); idle("R6");
        // R6 change-enable clear: no write, and R7 cancels
        sig(SIO, "R6"); cyc(1, P0 + 12'd2, 8'hFE, 0, 0, 0, 0, "R6"); idle("R7");
        // R6 address just past range
        sig(SIO, "R6"); cyc(1, P0 + 12'd4, 8'h01, 0, 0, 0, 0, "R6"); idle("R7");
        sig(SIO, "R6"); cyc(1, P0 + 12'd3, 8'h01, 0, 0, 0, 0, "R6"); idle("R6");
        // R5 window lapses on the fourth tick
        sig(SIO, "R5"); tick("R5"); tick("R5"); tick("R5"); idle("R5");
        tick("R5"); idle("R5");
        sig(SIN, "R5"); tick("R5"); tick("R5"); idle("R5"); tick("R5"); tick("R5"); idle("R5");
        // R10 restart, signature beats tick in the same cycle
        sig(SIO, "R10"); tick("R10"); tick("R10"); tick("R10");
        cyc(1, CCP, SIO, 1, 0, 0, 0, "R10");
        tick("R10"); tick("R10"); tick("R10"); idle("R10"); tick("R10"); idle("R10");
        // R4 other values ignored, window keeps counting
        sig(SIO, "R4"); tick("R4"); sig(8'h55, "R4"); idle("R4");
        sig(8'hD9, "R4"); tick("R4"); tick("R4"); idle("R4"); tick("R4"); idle("R4");
        sig(8'h00, "R4"); idle("R4");
        // R7 plain write elsewhere
        sig(SIO, "R7"); cyc(1, 12'h100, 8'h00, 0, 0, 0, 0, "R7"); idle("R7");
        sig(SIN, "R7"); cyc(1, 12'h200, 8'hFF, 0, 0, 0, 0, "R7"); idle("R7");
        // R3 mode switching by latest signature
        sig(SIN, "R3"); idle("R3"); sig(SIO, "R3"); idle("R3"); sig(SIN, "R3"); idle("R3");
        // R9 allow and consume
        cyc(0, CCP, 8'h00, 0, 1, 0, 0, "R9"); idle("R9");
        cyc(0, CCP, 8'h00, 0, 1, 0, 0, "R9");
        sig(SIN, "R9"); cyc(0, CCP, 8'h00, 0, 0, 1, 0, "R9"); idle("R9");
        // R8 cancellation by executed instructions
        sig(SIO, "R8"); cyc(0, CCP, 8'h00, 0, 0, 0, 1, "R8"); idle("R8");
        sig(SIN, "R8"); cyc(0, CCP, 8'h00, 0, 0, 0, 1, "R8"); idle("R8");
        sig(SIO, "R8"); cyc(0, CCP, 8'h00, 0, 0, 1, 0, "R8"); idle("R8");
        sig(SIO, "R8"); cyc(0, CCP, 8'h00, 0, 1, 0, 0, "R8"); idle("R8");
        idle("R1");
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule